// File: doc/BRIEF.md
# General-purpose I/O port with per-pin peripheral override

This block is one parallel I/O port of `WIDTH` pins (eight by default). Software sets each pin's data direction and output/pull-up bit through a small register interface and reads the pin levels back through a two-flop synchronizer. The block drives four pad controls per pin: output enable, output value, pull-up enable and input enable. It also takes the level from the pad.

Peripheral modules can take over any pad control of any pin. Each control has an enable/value pair. While the enable is high, the value fully replaces the control that the registers would otherwise produce. Peripherals also receive a raw copy of the pad input, gated by the input enable but taken before the synchronizer. A peripheral that uses this copy as data synchronizes it itself. A peripheral that uses it as a clock may take it directly.

Top module: `gpio_altport`

## Requirements
- R1: After reset, the direction and port registers read as all zeros. With no override active, every pin then has output enable 0 and pull-up 0.
- R2: When a pin's pull-up override enable is low, its pull-up is on only when direction = 0, port bit = 1 and the global pull-up disable = 0.
- R3: When a pin's pull-up override enable is high, its pull-up equals the pull-up override value. Direction, port bit and global disable have no effect.
- R4: A pin's output enable equals its direction bit when the direction override enable is low. It equals the direction override value when that enable is high.
- R5: A pin drives its value override when its output enable and its value override enable are both high. In every other case it drives its port register bit.
- R6: When the input-enable override enable is low, a pin's input enable is 1 outside sleep and 0 in sleep. When that enable is high, the input enable equals the override value.
- R7: The raw input to peripherals is the pad input ANDed with the pin's input enable. It changes in the same cycle as the pad input and is 0 whenever the input enable is 0.
- R8: Address 2 reads the pin register. It holds the gated pad input delayed by two rising clock edges.
- R9: A write with address 0 loads the direction register and a write with address 1 loads the port register. Either one reads back at the same address on the next cycle. Address 3 reads as zero.
- R10: Writes to address 2 or address 3 leave both the direction and the port register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 direction, 1 port, 2 pin, 3 none |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data for the selected register |
| pull_disable | input | 1 | Global pull-up disable |
| sleep_mode | input | 1 | Device is in a sleep state |
| pu_ovr_en | input | WIDTH | Pull-up override enable per pin |
| pu_ovr_val | input | WIDTH | Pull-up override value per pin |
| dir_ovr_en | input | WIDTH | Output-enable override enable per pin |
| dir_ovr_val | input | WIDTH | Output-enable override value per pin |
| val_ovr_en | input | WIDTH | Output-value override enable per pin |
| val_ovr_val | input | WIDTH | Output-value override value per pin |
| ie_ovr_en | input | WIDTH | Input-enable override enable per pin |
| ie_ovr_val | input | WIDTH | Input-enable override value per pin |
| pad_in | input | WIDTH | Level seen at the pads |
| pad_oe | output | WIDTH | Output driver enable per pin |
| pad_out | output | WIDTH | Driven value per pin |
| pad_pullup | output | WIDTH | Pull-up enable per pin |
| pad_ie | output | WIDTH | Digital input enable per pin |
| alt_din | output | WIDTH | Gated raw pad input for peripherals |

## Verification
The bench builds the port with the default `WIDTH` of 8. Each random round draws every override vector independently for all eight pins, so overridden and register-controlled pins are checked side by side in the same cycle. The per-bit rules can therefore disagree from one pin to the next, and a bit-slice or polarity mistake on any single pin shows up. Directed steps set the pad input to a known value and read the pin register after one edge and after two edges, which confirms the exact two-edge latency. They also check the sleep gating and the ignored writes.

// File: rtl/gpio_alt_pkg.sv
package gpio_alt_pkg;
    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_PORT = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_alt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] port_q
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] port;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            case (reg_sel_e'(reg_addr))
                SEL_DIR:  st_d.dir  = reg_wdata;
                SEL_PORT: st_d.port = reg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q  = st_q.dir;
    assign port_q = st_q.port;

    // R9: a direction write is visible on the next cycle
    a_r9_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0) |=> (dir_q == $past(reg_wdata)));
    // R10: writes to the pin or unused address leave both registers alone
    a_r10_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[1]) |=> ($stable(dir_q) && $stable(port_q)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] port_q,
    input  logic             pull_disable,
    input  logic             sleep_mode,
    input  logic [WIDTH-1:0] pu_ovr_en,
    input  logic [WIDTH-1:0] pu_ovr_val,
    input  logic [WIDTH-1:0] dir_ovr_en,
    input  logic [WIDTH-1:0] dir_ovr_val,
    input  logic [WIDTH-1:0] val_ovr_en,
    input  logic [WIDTH-1:0] val_ovr_val,
    input  logic [WIDTH-1:0] ie_ovr_en,
    input  logic [WIDTH-1:0] ie_ovr_val,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pullup,
    output logic [WIDTH-1:0] pad_ie
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic oe_d;
        always_comb begin
            // register-derived pull-up: input pin, port bit set, not globally disabled
            pad_pullup[i] = pu_ovr_en[i] ? pu_ovr_val[i]
                          : ({dir_q[i], port_q[i], pull_disable} == 3'b010);
            oe_d          = dir_ovr_en[i] ? dir_ovr_val[i] : dir_q[i];
            pad_oe[i]     = oe_d;
            pad_out[i]    = (oe_d && val_ovr_en[i]) ? val_ovr_val[i] : port_q[i];
            pad_ie[i]     = ie_ovr_en[i] ? ie_ovr_val[i] : !sleep_mode;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] pad_ie,
    output logic [WIDTH-1:0] raw_o,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;
    logic [1:0] age_d, age_q;

    always_comb begin
        raw_o   = pad_in & pad_ie;
        st_d.s1 = raw_o;
        st_d.s2 = st_q.s1;
        age_d   = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            age_q <= '0;
        end else begin
            st_q  <= st_d;
            age_q <= age_d;
        end
    end

    assign sync_o = st_q.s2;

    // R8: the pin value is the gated input from two edges earlier
    a_r8_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (sync_o == $past(raw_o, 2)));
    // R7: no raw bit reaches peripherals while its input is disabled
    a_r7_raw_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_o & ~pad_ie) == '0));
endmodule

// File: rtl/gpio_altport.sv
module gpio_altport
    import gpio_alt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic             pull_disable,
    input  logic             sleep_mode,
    input  logic [WIDTH-1:0] pu_ovr_en,
    input  logic [WIDTH-1:0] pu_ovr_val,
    input  logic [WIDTH-1:0] dir_ovr_en,
    input  logic [WIDTH-1:0] dir_ovr_val,
    input  logic [WIDTH-1:0] val_ovr_en,
    input  logic [WIDTH-1:0] val_ovr_val,
    input  logic [WIDTH-1:0] ie_ovr_en,
    input  logic [WIDTH-1:0] ie_ovr_val,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pullup,
    output logic [WIDTH-1:0] pad_ie,
    output logic [WIDTH-1:0] alt_din
);
    logic [WIDTH-1:0] dir_q, port_q, pin_q;

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .dir_q(dir_q), .port_q(port_q)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .dir_q(dir_q), .port_q(port_q), .pull_disable(pull_disable),
        .sleep_mode(sleep_mode),
        .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val),
        .dir_ovr_en(dir_ovr_en), .dir_ovr_val(dir_ovr_val),
        .val_ovr_en(val_ovr_en), .val_ovr_val(val_ovr_val),
        .ie_ovr_en(ie_ovr_en), .ie_ovr_val(ie_ovr_val),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pullup(pad_pullup),
        .pad_ie(pad_ie)
    );

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_ie(pad_ie),
        .raw_o(alt_din), .sync_o(pin_q)
    );

    always_comb begin
        case (reg_sel_e'(reg_addr))
            SEL_DIR:  reg_rdata = dir_q;
            SEL_PORT: reg_rdata = port_q;
            SEL_PIN:  reg_rdata = pin_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R2: without a pull-up override an output pin never has its pull-up on
    a_r2_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pu_ovr_en & dir_q & pad_pullup) == '0));
    // R4: without a direction override the driver follows the direction register
    a_r4_oe_from_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_ovr_en & (pad_oe ^ dir_q)) == '0));
endmodule

// File: tb/tb_gpio_altport.sv
`timescale 1ns/1ps
module tb_gpio_altport;
    localparam int W = 8;

    logic clk = 0, rst_n = 0;
    logic [1:0] reg_addr = 0;
    logic reg_we = 0;
    logic [W-1:0] reg_wdata = 0, reg_rdata;
    logic pull_disable = 0, sleep_mode = 0;
    logic [W-1:0] pu_en = 0, pu_v = 0, dr_en = 0, dr_v = 0;
    logic [W-1:0] vl_en = 0, vl_v = 0, ie_en = 0, ie_v = 0, pad_in = 0;
    logic [W-1:0] pad_oe, pad_out, pad_pullup, pad_ie, alt_din;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_altport #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pull_disable(pull_disable), .sleep_mode(sleep_mode),
        .pu_ovr_en(pu_en), .pu_ovr_val(pu_v), .dir_ovr_en(dr_en), .dir_ovr_val(dr_v),
        .val_ovr_en(vl_en), .val_ovr_val(vl_v), .ie_ovr_en(ie_en), .ie_ovr_val(ie_v),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pullup(pad_pullup), .pad_ie(pad_ie), .alt_din(alt_din)
    );

    function automatic logic [W-1:0] f_pu(logic [W-1:0] d, logic [W-1:0] p);
        return (pu_en & pu_v) | (~pu_en & ~d & p & {W{~pull_disable}});
    endfunction
    function automatic logic [W-1:0] f_oe(logic [W-1:0] d);
        return (dr_en & dr_v) | (~dr_en & d);
    endfunction
    function automatic logic [W-1:0] f_out(logic [W-1:0] d, logic [W-1:0] p);
        logic [W-1:0] sel;
        sel = f_oe(d) & vl_en;
        return (sel & vl_v) | (~sel & p);
    endfunction
    function automatic logic [W-1:0] f_ie();
        return (ie_en & ie_v) | (~ie_en & {W{~sleep_mode}});
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [W-1:0] d);
        reg_addr = a; #0.5; d = reg_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d, p, r, a, b;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        rd(2'd0, r); chk("R1 dir reset", r, '0);
        rd(2'd1, r); chk("R1 port reset", r, '0);
        #0.5; chk("R1 oe reset", pad_oe, '0);
        chk("R1 pullup reset", pad_pullup, '0);
        rd(2'd3, r); chk("R9 addr3 reads zero", r, '0);

        // R2 directed: dir=0x0F, port=0x33, no overrides
        wr(2'd0, 8'h0F); wr(2'd1, 8'h33);
        #0.5; chk("R2 pull-up rule", pad_pullup, 8'h30);
        pull_disable = 1; #0.5; chk("R2 global disable", pad_pullup, 8'h00);
        // R3: override ignores the global disable and the direction
        pu_en = 8'hFF; pu_v = 8'hA5; #0.5; chk("R3 pull-up override", pad_pullup, 8'hA5);
        pu_en = 0; pu_v = 0; pull_disable = 0;

        // R10: writes to addresses 2 and 3 ignored
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        rd(2'd0, r); chk("R10 dir unchanged", r, 8'h0F);
        rd(2'd1, r); chk("R10 port unchanged", r, 8'h33);

        // R8: two-edge latency of the pin register
        pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        rd(2'd2, r); chk("R8 settled", r, 8'h3C);
        pad_in = 8'hC9;
        @(negedge clk); rd(2'd2, r); chk("R8 one edge still old", r, 8'h3C);
        @(negedge clk); rd(2'd2, r); chk("R8 two edges new", r, 8'hC9);

        // R6/R7: sleep gating of input and raw path
        sleep_mode = 1; pad_in = 8'hFF; #0.5;
        chk("R6 sleep ie", pad_ie, 8'h00);
        chk("R7 raw gated in sleep", alt_din, 8'h00);
        repeat (3) @(negedge clk);
        rd(2'd2, r); chk("R8 pin zero in sleep", r, 8'h00);
        ie_en = 8'h0F; ie_v = 8'h05; #0.5;
        chk("R6 ie override", pad_ie, 8'h05);
        chk("R7 raw follows override", alt_din, 8'h05);
        sleep_mode = 0; ie_en = 0; ie_v = 0;

        // random rounds
        for (int k = 0; k < 200; k++) begin
            d = $urandom; p = $urandom;
            wr(2'd0, d); wr(2'd1, p);
            rd(2'd0, r); chk("R9 dir readback", r, d);
            rd(2'd1, r); chk("R9 port readback", r, p);
            if (k % 8 == 0) begin
                b = $urandom;
                wr(2'd2 + 2'($urandom % 2), b);
                rd(2'd0, r); chk("R10 dir after ro write", r, d);
                rd(2'd1, r); chk("R10 port after ro write", r, p);
            end
            pull_disable = $urandom; sleep_mode = $urandom;
            pu_en = $urandom; pu_v = $urandom; dr_en = $urandom; dr_v = $urandom;
            vl_en = $urandom; vl_v = $urandom; ie_en = $urandom; ie_v = $urandom;
            a = $urandom; pad_in = a;
            #0.5;
            chk("R2 R3 pullup", pad_pullup, f_pu(d, p));
            chk("R4 oe", pad_oe, f_oe(d));
            chk("R5 out", pad_out, f_out(d, p));
            chk("R6 ie", pad_ie, f_ie());
            chk("R7 raw", alt_din, a & f_ie());
            @(negedge clk); @(negedge clk);
            rd(2'd2, r); chk("R8 pin random", r, a & f_ie());
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule